// File: doc/BRIEF.md
# Clock Output Stop and Enable Controller

This block sits between a clock synthesiser and the output pins of a clock generator. It gates three differential CPU clock pairs, one differential SRC pair and a group of single-ended PCI clocks. Gating follows a small byte-wide register file, two active-low stop pins, a power-down input and a software stop bit. Each output can toggle normally, be held at a fixed level, or, for the pairs only, be released to high impedance. High impedance is reported on a separate output-enable signal for each pair.

Every change of gating state goes through two flops in the output's own source clock domain. The change then takes effect on a falling edge of that source clock. A change can therefore never cut a high phase short or insert an extra edge. For each pair, the register file chooses whether the pair is held or floated when stopped, and separately whether it is held or floated in power-down. The register file also reports the live stop pins and the frequency-select pins latched during reset.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset the registers read as follows: address 1 reads 0xEF, address 2 reads 0x00 and address 3 reads 0xFF. All outputs toggle and every pair output-enable is 1.
- R2: While an output is enabled, each high phase and each low phase lasts at least half a period of its source clock. This holds across any stop, resume, power-down or mode change.
- R3: While a pair is driven, its complement output is the inverse of its true output. A held pair keeps the true output low and the complement output high.
- R4: When a pair's enable bit is 0, the pair's output-enable goes low and stays low within four source clock cycles. The enable bits are address 1 bits 2:0 for CPU pairs 0..2 and bit 3 for SRC. A disabled pair stays floated regardless of power-down or stop.
- R5: The PCI stop condition is the pin pci_stop_n at 0 or the software run bit (address 3 bit 7) written 0. It holds every PCI output low. The SRC pair stops with it only when address 1 bit 4 is 1; with that bit at 0 (its reset value) SRC keeps toggling.
- R6: cpu_stop_n at 0 stops the CPU pairs. A pair whose stop-float bit is 0 is held; with the bit at 1 the pair is floated. The stop-float bits are address 2 bits 2:0 for CPU pairs and bit 3 for SRC.
- R7: pwr_down at 1 stops all outputs. A pair whose power-down-float bit is 1 is floated; with the bit at 0 it is held. The power-down-float bits are address 2 bits 6:4 for CPU pairs and bit 7 for SRC. Power-down takes priority over the stop float setting.
- R8: A PCI output whose enable bit is 0 is held low while the other PCI outputs keep toggling. The enable bits are address 3 bits 3:0.
- R9: Address 0 is a read-only status register. Bit 0 and bit 1 hold fsel_a and fsel_b as latched during reset and never change afterwards. Bit 2 and bit 3 follow cpu_stop_n and pci_stop_n after a two-flop synchroniser. Bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register file clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational on addr) |
| fsel_a | input | 1 | Frequency-select pin A, latched during reset |
| fsel_b | input | 1 | Frequency-select pin B, latched during reset |
| cpu_stop_n | input | 1 | Active-low CPU stop pin |
| pci_stop_n | input | 1 | Active-low PCI stop pin |
| pwr_down | input | 1 | Power-down request, active high |
| cpu_clk | input | 1 | Source clock of the CPU pairs |
| src_clk | input | 1 | Source clock of the SRC pair |
| pci_clk | input | 1 | Source clock of the PCI outputs |
| cpu_t | output | 3 | CPU pair true outputs |
| cpu_c | output | 3 | CPU pair complement outputs |
| cpu_oe | output | 3 | CPU pair output enables (0 = high impedance) |
| src_t | output | 1 | SRC pair true output |
| src_c | output | 1 | SRC pair complement output |
| src_oe | output | 1 | SRC pair output enable (0 = high impedance) |
| pci_out | output | 4 | Single-ended PCI clock outputs |

## Verification
The assertions assume that every source clock runs freely, including during reset. They also assume that reset is held for several periods of the slowest source clock, so that each domain's synchroniser and applied state are cleared before checking starts. The latched-status property further assumes that fsel_a and fsel_b are steady over the last cycles of reset. The bench starts all three source clocks at time zero and holds reset for twenty register clock cycles. It changes the frequency-select pins only well after reset is released, and it writes registers only on falling edges of the register clock.

// File: rtl/clkgate_pkg.sv
// Package for the clock output gating controller.
// Holds register geometry, the register address map and the priority
// function that turns one pair's controls into a {float, run} request.
package clkgate_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_DRIVE  = 2'd2,
        REG_PCI    = 2'd3
    } reg_sel_e;

    // Priority: disabled > power-down > stopped > toggling. Returns {float, run}.
    function automatic logic [1:0] pair_mode(
        input logic oe,
        input logic pd,
        input logic stopped,
        input logic pd_float,
        input logic stop_float
    );
        if (!oe)          return 2'b10;
        else if (pd)      return {pd_float, 1'b0};
        else if (stopped) return {stop_float, 1'b0};
        else              return 2'b01;
    endfunction

endpackage

// File: rtl/clkgate_cell.sv
// Glitch-free gating state for one source clock domain.
// Takes a W-bit request from any domain. It passes the request through two
// flops on the rising edge of clk_in and applies it on the falling edge, so
// the applied state only changes while clk_in is low.
// Assumes: clk_in runs during reset; rst_n is held for several clk_in cycles.
module clkgate_cell #(
    parameter int W = 2
) (
    input  logic         clk_in,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    output logic [W-1:0] applied
);

    logic [W-1:0] sync1_q;
    logic [W-1:0] sync2_q;

    // Two-flop synchroniser into the source clock domain.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= req;
            sync2_q <= sync1_q;
        end
    end

    // Apply the synchronised request while the source clock is low.
    always_ff @(negedge clk_in) begin
        if (!rst_n) applied <= '0;
        else        applied <= sync2_q;
    end

endmodule

// File: rtl/clkgate_regs.sv
// Byte-wide control and status registers.
// Address map and field positions are given in the brief. Reserved bits are
// stored and read back. The status register latches the frequency-select
// pins while reset is asserted and synchronises the live stop pins.
// Assumes: fsel pins are steady over the last cycles of reset.
module clkgate_regs
    import clkgate_pkg::*;
#(
    parameter int N_CPU = 3,
    parameter int N_PCI = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wr_data,
    output logic [REG_DW-1:0] rd_data,
    input  logic              fsel_a,
    input  logic              fsel_b,
    input  logic              cpu_stop_n,
    input  logic              pci_stop_n,
    output logic [N_CPU-1:0]  cpu_oe,
    output logic [N_CPU-1:0]  cpu_stop_float,
    output logic [N_CPU-1:0]  cpu_pd_float,
    output logic              src_oe,
    output logic              src_stoppable,
    output logic              src_stop_float,
    output logic              src_pd_float,
    output logic              sw_run,
    output logic [N_PCI-1:0]  pci_en
);

    localparam int SRC_OE_BIT    = N_CPU;
    localparam int STOPPABLE_BIT = N_CPU + 1;
    localparam int PD_BASE       = N_CPU + 1;
    localparam int SRC_PD_BIT    = 2 * N_CPU + 1;
    localparam int SW_RUN_BIT    = REG_DW - 1;
    localparam logic [REG_DW-1:0] EN_RST  = ~(REG_DW'(1) << STOPPABLE_BIT);
    localparam logic [REG_DW-1:0] DRV_RST = '0;
    localparam logic [REG_DW-1:0] PCI_RST = '1;

    logic [REG_DW-1:0] en_q;
    logic [REG_DW-1:0] drv_q;
    logic [REG_DW-1:0] pci_q;
    logic [1:0]        fsel_q;
    logic [1:0]        pin_s1_q;
    logic [1:0]        pin_s2_q;

    // Register writes; the status address ignores writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= EN_RST;
            drv_q <= DRV_RST;
            pci_q <= PCI_RST;
        end else if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_ENABLE: en_q  <= wr_data;
                REG_DRIVE:  drv_q <= wr_data;
                REG_PCI:    pci_q <= wr_data;
                default:    ;
            endcase
        end
    end

    // Latch the frequency-select pins during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) fsel_q <= {fsel_b, fsel_a};
    end

    // Synchronise the live stop pins for status read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1_q <= 2'b11;
            pin_s2_q <= 2'b11;
        end else begin
            pin_s1_q <= {pci_stop_n, cpu_stop_n};
            pin_s2_q <= pin_s1_q;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(addr))
            REG_STATUS: rd_data[3:0] = {pin_s2_q, fsel_q};
            REG_ENABLE: rd_data = en_q;
            REG_DRIVE:  rd_data = drv_q;
            REG_PCI:    rd_data = pci_q;
            default:    rd_data = '0;
        endcase
    end

    assign cpu_oe         = en_q[N_CPU-1:0];
    assign src_oe         = en_q[SRC_OE_BIT];
    assign src_stoppable  = en_q[STOPPABLE_BIT];
    assign cpu_stop_float = drv_q[N_CPU-1:0];
    assign src_stop_float = drv_q[N_CPU];
    assign cpu_pd_float   = drv_q[PD_BASE +: N_CPU];
    assign src_pd_float   = drv_q[SRC_PD_BIT];
    assign sw_run         = pci_q[SW_RUN_BIT];
    assign pci_en         = pci_q[N_PCI-1:0];

endmodule

// File: rtl/clkgate_policy.sv
// Combinational gating policy.
// Resolves register fields and pins into one {float, run} request per pair
// and one run request per PCI output. The pins may be asynchronous; every
// result is synchronised later by clkgate_cell.
module clkgate_policy
    import clkgate_pkg::*;
#(
    parameter int N_CPU = 3,
    parameter int N_PCI = 4
) (
    input  logic [N_CPU-1:0] cpu_oe,
    input  logic [N_CPU-1:0] cpu_stop_float,
    input  logic [N_CPU-1:0] cpu_pd_float,
    input  logic             src_oe,
    input  logic             src_stoppable,
    input  logic             src_stop_float,
    input  logic             src_pd_float,
    input  logic             sw_run,
    input  logic [N_PCI-1:0] pci_en,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_down,
    output logic [N_CPU-1:0] cpu_run,
    output logic [N_CPU-1:0] cpu_float,
    output logic             src_run,
    output logic             src_float,
    output logic [N_PCI-1:0] pci_run
);

    logic pci_stop;

    assign pci_stop = !pci_stop_n || !sw_run;

    // One priority resolver per CPU pair.
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        assign {cpu_float[i], cpu_run[i]} =
            pair_mode(cpu_oe[i], pwr_down, !cpu_stop_n, cpu_pd_float[i], cpu_stop_float[i]);
    end

    // SRC follows the PCI stop only when marked stoppable.
    assign {src_float, src_run} =
        pair_mode(src_oe, pwr_down, src_stoppable && pci_stop, src_pd_float, src_stop_float);

    // PCI outputs run when enabled and neither stopped nor powered down.
    assign pci_run = pci_en & {N_PCI{!(pwr_down || pci_stop)}};

endmodule

// File: rtl/clkgate_ctrl.sv
// Clock output stop and enable controller (top).
// Gates CPU pairs, an SRC pair and PCI outputs from their source clocks.
// State changes only while the source clock is low, so no pulse is ever
// shortened. Floating is reported on per-pair output-enable signals.
// Assumes: source clocks run freely; N_CPU <= 3 and N_PCI <= 7 so that the
// fields fit the byte registers.
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N_CPU = 3,
    parameter int N_PCI = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wr_data,
    output logic [REG_DW-1:0] rd_data,
    input  logic              fsel_a,
    input  logic              fsel_b,
    input  logic              cpu_stop_n,
    input  logic              pci_stop_n,
    input  logic              pwr_down,
    input  logic              cpu_clk,
    input  logic              src_clk,
    input  logic              pci_clk,
    output logic [N_CPU-1:0]  cpu_t,
    output logic [N_CPU-1:0]  cpu_c,
    output logic [N_CPU-1:0]  cpu_oe,
    output logic              src_t,
    output logic              src_c,
    output logic              src_oe,
    output logic [N_PCI-1:0]  pci_out
);

    logic [N_CPU-1:0] cpu_oe_cfg, cpu_stop_float, cpu_pd_float;
    logic             src_oe_cfg, src_stoppable, src_stop_float, src_pd_float, sw_run;
    logic [N_PCI-1:0] pci_en;
    logic [N_CPU-1:0] cpu_run_req, cpu_float_req;
    logic             src_run_req, src_float_req;
    logic [N_PCI-1:0] pci_run_req;
    logic [1:0]       src_app;
    logic [N_PCI-1:0] pci_app;

    clkgate_regs #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .addr           (addr),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .fsel_a         (fsel_a),
        .fsel_b         (fsel_b),
        .cpu_stop_n     (cpu_stop_n),
        .pci_stop_n     (pci_stop_n),
        .cpu_oe         (cpu_oe_cfg),
        .cpu_stop_float (cpu_stop_float),
        .cpu_pd_float   (cpu_pd_float),
        .src_oe         (src_oe_cfg),
        .src_stoppable  (src_stoppable),
        .src_stop_float (src_stop_float),
        .src_pd_float   (src_pd_float),
        .sw_run         (sw_run),
        .pci_en         (pci_en)
    );

    clkgate_policy #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_policy (
        .cpu_oe         (cpu_oe_cfg),
        .cpu_stop_float (cpu_stop_float),
        .cpu_pd_float   (cpu_pd_float),
        .src_oe         (src_oe_cfg),
        .src_stoppable  (src_stoppable),
        .src_stop_float (src_stop_float),
        .src_pd_float   (src_pd_float),
        .sw_run         (sw_run),
        .pci_en         (pci_en),
        .cpu_stop_n     (cpu_stop_n),
        .pci_stop_n     (pci_stop_n),
        .pwr_down       (pwr_down),
        .cpu_run        (cpu_run_req),
        .cpu_float      (cpu_float_req),
        .src_run        (src_run_req),
        .src_float      (src_float_req),
        .pci_run        (pci_run_req)
    );

    // One gating cell per CPU pair in the CPU source domain.
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        logic [1:0] app;
        clkgate_cell #(.W(2)) u_cell (
            .clk_in  (cpu_clk),
            .rst_n   (rst_n),
            .req     ({cpu_float_req[i], cpu_run_req[i]}),
            .applied (app)
        );
        assign cpu_t[i]  = cpu_clk & app[0];
        assign cpu_c[i]  = ~(cpu_clk & app[0]);
        assign cpu_oe[i] = ~app[1];
    end

    clkgate_cell #(.W(2)) u_src_cell (
        .clk_in  (src_clk),
        .rst_n   (rst_n),
        .req     ({src_float_req, src_run_req}),
        .applied (src_app)
    );
    assign src_t  = src_clk & src_app[0];
    assign src_c  = ~(src_clk & src_app[0]);
    assign src_oe = ~src_app[1];

    clkgate_cell #(.W(N_PCI)) u_pci_cell (
        .clk_in  (pci_clk),
        .rst_n   (rst_n),
        .req     (pci_run_req),
        .applied (pci_app)
    );
    assign pci_out = {N_PCI{pci_clk}} & pci_app;

endmodule

// File: rtl/clkgate_ctrl_chk.sv
// Assertion checker for clkgate_ctrl, attached by bind below.
// Assumes free-running source clocks and a reset longer than a few cycles
// of the slowest source clock.
module clkgate_ctrl_chk
    import clkgate_pkg::*;
#(
    parameter int N_CPU = 3,
    parameter int N_PCI = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] addr,
    input logic [REG_DW-1:0] rd_data,
    input logic              cpu_clk,
    input logic              pci_clk,
    input logic [N_CPU-1:0]  cpu_t,
    input logic [N_CPU-1:0]  cpu_c,
    input logic [N_CPU-1:0]  cpu_oe,
    input logic [N_CPU-1:0]  cpu_oe_cfg,
    input logic [N_PCI-1:0]  pci_out
);

    for (genvar i = 0; i < N_CPU; i++) begin : g_pair
        // R2: a CPU true output is never high while its source clock is low.
        a_r2_cpu_low_with_source: assert property (@(posedge cpu_clk) disable iff (!rst_n)
            !cpu_t[i]);
        // R3: complement mirrors the true output.
        a_r3_complement: assert property (@(negedge cpu_clk) disable iff (!rst_n)
            cpu_c[i] == !cpu_t[i]);
        // R4: a pair disabled for four source cycles is floated.
        a_r4_disable_floats: assert property (@(negedge cpu_clk) disable iff (!rst_n)
            (!cpu_oe_cfg[i] && !$past(cpu_oe_cfg[i], 1) && !$past(cpu_oe_cfg[i], 2)
             && !$past(cpu_oe_cfg[i], 3)) |-> !cpu_oe[i]);
    end

    // R2: PCI outputs are never high while their source clock is low.
    a_r2_pci_low_with_source: assert property (@(posedge pci_clk) disable iff (!rst_n)
        pci_out == '0);

    // R9: latched frequency-select status never changes after reset.
    a_r9_fsel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_AW'(0) && $past(addr) == REG_AW'(0)) |-> rd_data[1:0] == $past(rd_data[1:0]));

endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_data    (rd_data),
    .cpu_clk    (cpu_clk),
    .pci_clk    (pci_clk),
    .cpu_t      (cpu_t),
    .cpu_c      (cpu_c),
    .cpu_oe     (cpu_oe),
    .cpu_oe_cfg (cpu_oe_cfg),
    .pci_out    (pci_out)
);

// File: tb/clkgate_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for clkgate_ctrl: one task per scenario, plus a running
// pulse-width monitor on every output.
module clkgate_ctrl_test;

    localparam int N_CPU = 3;
    localparam int N_PCI = 4;
    localparam int NMON  = 2 * N_CPU + 2 + N_PCI;

    logic clk = 1'b0, cpu_clk = 1'b0, src_clk = 1'b0, pci_clk = 1'b0;
    logic rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic fsel_a = 1'b1, fsel_b = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_down = 1'b0;
    logic [N_CPU-1:0] cpu_t, cpu_c, cpu_oe;
    logic src_t, src_c, src_oe;
    logic [N_PCI-1:0] pci_out;
    logic [NMON-1:0] mon;
    logic [3:0] oe_all;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk     = ~clk;
    always #3.1 cpu_clk = ~cpu_clk;
    always #4.3 src_clk = ~src_clk;
    always #7.3 pci_clk = ~pci_clk;

    clkgate_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .fsel_a(fsel_a), .fsel_b(fsel_b),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_down(pwr_down),
        .cpu_clk(cpu_clk), .src_clk(src_clk), .pci_clk(pci_clk),
        .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe),
        .src_t(src_t), .src_c(src_c), .src_oe(src_oe), .pci_out(pci_out)
    );

    // Monitor bits: 0-2 cpu_t, 3-5 cpu_c, 6 src_t, 7 src_c, 8-11 pci_out.
    assign mon    = {pci_out, src_c, src_t, cpu_c, cpu_t};
    assign oe_all = {src_oe, cpu_oe};

    function automatic real half_of(int b);
        if (b < 6) return 3.1;
        if (b < 8) return 4.3;
        return 7.3;
    endfunction

    function automatic logic oe_of(int b);
        if (b < 3) return oe_all[b];
        if (b < 6) return oe_all[b-3];
        if (b < 8) return oe_all[3];
        return 1'b1;
    endfunction

    // R2: every enabled phase lasts at least a source half period.
    for (genvar g = 0; g < NMON; g++) begin : g_pw
        real last_edge = -1.0;
        always @(mon[g]) begin
            if (rst_n && oe_of(g) && last_edge >= 0.0) begin
                checks++;
                if ($realtime - last_edge < half_of(g) - 0.001) begin
                    errors++;
                    $display("FAIL R2 bit %0d phase %0.3f ns expected >= %0.3f ns",
                             g, $realtime - last_edge, half_of(g));
                end
            end
            last_edge = $realtime;
        end
    end

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rd_data;
    endtask

    // Settle, then sample for several periods of the slowest source clock.
    // exp_tog: outputs that must toggle; exp_hi: held outputs that sit high.
    task automatic observe(string req, logic [NMON-1:0] exp_tog,
                           logic [NMON-1:0] exp_hi, logic [3:0] exp_oe);
        logic [NMON-1:0] hi = '0, lo = '0;
        logic [3:0] oe_and = '1, oe_or = '0;
        int comp_err = 0;
        #300;
        for (int k = 0; k < 64; k++) begin
            #1.7;
            hi |= mon;
            lo |= ~mon;
            oe_and &= oe_all;
            oe_or  |= oe_all;
            if (cpu_c !== ~cpu_t || src_c !== ~src_t) comp_err++;
        end
        chk({req, " toggling"}, 16'(hi & lo), 16'(exp_tog));
        chk({req, " held high"}, 16'(hi & ~lo), 16'(exp_hi));
        chk({req, " oe steady-low"}, 16'(oe_and), 16'(exp_oe));
        chk({req, " oe steady-high"}, 16'(oe_or), 16'(exp_oe));
        chk("R3 complement", 16'(comp_err), 16'd0);
    endtask

    task automatic t_reset_values();
        logic [7:0] d;
        rd(2'd1, d); chk("R1 enable reg", 16'(d), 16'h00EF);
        rd(2'd2, d); chk("R1 drive reg", 16'(d), 16'h0000);
        rd(2'd3, d); chk("R1 pci reg", 16'(d), 16'h00FF);
        rd(2'd0, d); chk("R9 status after reset", 16'(d), 16'h000D);
        observe("R1 reset outputs", 12'hFFF, 12'h000, 4'hF);
        fsel_a = 1'b0; fsel_b = 1'b1;
        repeat (5) @(negedge clk);
        rd(2'd0, d); chk("R9 fsel frozen", 16'(d), 16'h000D);
    endtask

    task automatic t_pci_stop_pin();
        pci_stop_n = 1'b0;
        observe("R5 pin stop, SRC free", 12'h0FF, 12'h000, 4'hF);
        wr(2'd1, 8'hFF);
        observe("R5 pin stop, SRC stoppable", 12'h03F, 12'h080, 4'hF);
        pci_stop_n = 1'b1;
        observe("R5 pin release", 12'hFFF, 12'h000, 4'hF);
        wr(2'd1, 8'hEF);
    endtask

    task automatic t_sw_stop();
        wr(2'd3, 8'h7F);
        observe("R5 software stop", 12'h0FF, 12'h000, 4'hF);
        wr(2'd3, 8'hFF);
        observe("R5 software release", 12'hFFF, 12'h000, 4'hF);
    endtask

    task automatic t_cpu_stop();
        logic [7:0] d;
        wr(2'd2, 8'h02);
        cpu_stop_n = 1'b0;
        observe("R6 cpu stop, pair1 floated", 12'hFC0, 12'h038, 4'hD);
        rd(2'd0, d); chk("R9 live cpu stop pin", 16'(d[3:2]), 16'h2);
    endtask

    task automatic t_power_down();
        wr(2'd2, 8'h52);
        pwr_down = 1'b1;
        observe("R7 power-down over stop", 12'h000, 12'h0B8, 4'hA);
        pwr_down = 1'b0;
        cpu_stop_n = 1'b1;
        wr(2'd2, 8'h00);
        observe("R7 power-down exit", 12'hFFF, 12'h000, 4'hF);
    endtask

    task automatic t_disable();
        wr(2'd1, 8'hED);
        observe("R4 pair1 disabled", 12'hFED, 12'h010, 4'hD);
        pwr_down = 1'b1;
        observe("R4 disable over power-down", 12'h000, 12'h0B8, 4'hD);
        pwr_down = 1'b0;
        wr(2'd1, 8'hEF);
        observe("R4 re-enable", 12'hFFF, 12'h000, 4'hF);
    endtask

    task automatic t_pci_enable();
        logic [7:0] d;
        wr(2'd3, 8'hFA);
        observe("R8 pci 0 and 2 disabled", 12'hAFF, 12'h000, 4'hF);
        rd(2'd3, d); chk("R8 pci reg readback", 16'(d), 16'h00FA);
        wr(2'd3, 8'hFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_pci_stop_pin();
        t_sw_stop();
        t_cpu_stop();
        t_power_down();
        t_disable();
        t_pci_enable();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired got=running expected=finished");
        finish_run();
    end

endmodule